// File: doc/BRIEF.md
# Debounced Phase-Lock Indicator

This block sits behind a phase comparator in a motor speed loop. The comparator gives a raw "in phase" flag that only looks at phase error. While the loop is pulling in, that flag can flip on and off many times in quick succession. The block turns the raw flag into a clean lock output. It does this by requiring the flag to stay high for a programmable number of clock ticks before it reports lock. A digital run counter takes the place of a timing capacitor. The mask length is a count of ticks, and the delay grows linearly with it.

When the mask is turned off, the output copies the raw flag in the same cycle. When the raw flag is lost, the output drops on the next clock, with no extra delay. A stop command and reset both clear the run counter and hold the output off. The output is active high: 1 means the lock indicator is on, like an open-collector output pulled low.

Top module: `phase_lock_debounce`

## Requirements
- R1: While rst_n is low, lock_o is 0 and the consecutive-high run count is cleared, so after reset release a full run is needed before lock.
- R2: With mask_en_i = 1, lock_o becomes 1 after the clock edge at which raw_lock_i has been sampled 1 on max(mask_len_i, 1) consecutive edges, and not earlier.
- R3: With mask_en_i = 1, any edge that samples raw_lock_i = 0 restarts the run, so a pulse train shorter than the mask never produces lock.
- R4: With mask_en_i = 1, an edge that samples raw_lock_i = 0 makes lock_o 0 directly after that edge.
- R5: With mask_en_i = 0, lock_o equals raw_lock_i AND NOT stop_i in the same cycle, with no clock delay.
- R6: stop_i = 1 forces lock_o to 0 in the same cycle and clears the run at the next edge, so a full run is needed again after stop_i falls.
- R7: The run count saturates at 2^CNT_W-1 without wrapping, so lock holds through arbitrarily long runs, including at mask_len_i = 2^CNT_W-1.
- R8: The run count keeps advancing while the mask is bypassed, so enabling the mask after a run of at least mask_len_i edges shows lock at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Stop command; forces the indicator off |
| raw_lock_i | input | 1 | Raw in-phase flag from the phase comparator |
| mask_len_i | input | CNT_W | Mask length in clock ticks |
| mask_en_i | input | 1 | 1 = debounce active, 0 = bypass |
| lock_o | output | 1 | Lock indicator, 1 = on |

## Verification
The hardest case to reach is the exact boundary of the mask. A raw run one tick short of the mask length must give no lock, while a run of exactly that length must give lock. The same boundary must hold when a run is broken just before completion. The stimulus reaches these edges by driving pulse trains of precisely L-1, L and L+k high cycles, with single-cycle gaps. It also holds a run past the counter's saturation point at the largest mask length, using a narrow counter so that point is reached in a few dozen cycles.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  // next value of the consecutive-high run counter, saturating at top
  function automatic int unsigned run_next(input int unsigned cur,
                                           input bit hi,
                                           input int unsigned top);
    if (!hi) return 0;
    if (cur >= top) return top;
    return cur + 1;
  endfunction

  // a run of length run satisfies a mask of length len (zero acts as one)
  function automatic bit run_done(input int unsigned run,
                                  input int unsigned len);
    return (run != 0) && (run >= len);
  endfunction
endpackage

// File: rtl/lkd_run_counter.sv
module lkd_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             raw_i,
  output logic [CNT_W-1:0] run_q,
  output logic [CNT_W-1:0] run_nxt
);
  localparam int unsigned RUN_TOP = (32'd1 << CNT_W) - 32'd1;

  always_comb
    run_nxt = CNT_W'(lkd_pkg::run_next(32'(run_q), raw_i, RUN_TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (clr_i) run_q <= '0;
    else            run_q <= run_nxt;
  end

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_i |=> (run_q == '0));

  assert_stop_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (run_q == '0));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_i && !clr_i && 32'(run_q) == RUN_TOP) |=> (32'(run_q) == RUN_TOP));
endmodule

// File: rtl/lkd_hold_reg.sv
module lkd_hold_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] mask_len_i,
  input  logic [CNT_W-1:0] run_q_i,
  input  logic [CNT_W-1:0] run_nxt_i,
  output logic             lock_q
);
  logic done_w;

  always_comb done_w = lkd_pkg::run_done(32'(run_nxt_i), 32'(mask_len_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= 1'b0;
    else if (clr_i) lock_q <= 1'b0;
    else            lock_q <= raw_i & done_w;
  end

  assert_rise_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> (run_q_i != '0 && run_q_i >= $past(mask_len_i)));

  assert_fast_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_i |=> !lock_q);
endmodule

// File: rtl/lkd_out_sel.sv
module lkd_out_sel (
  input  logic lock_q_i,
  input  logic raw_i,
  input  logic stop_i,
  input  logic mask_en_i,
  output logic lock_o
);
  always_comb lock_o = ~stop_i & (mask_en_i ? lock_q_i : raw_i);
endmodule

// File: rtl/phase_lock_debounce.sv
module phase_lock_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             raw_lock_i,
  input  logic [CNT_W-1:0] mask_len_i,
  input  logic             mask_en_i,
  output logic             lock_o
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nxt;
  logic             lock_q;

  lkd_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(stop_i), .raw_i(raw_lock_i),
    .run_q(run_q), .run_nxt(run_nxt));

  lkd_hold_reg #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr_i(stop_i), .raw_i(raw_lock_i),
    .mask_len_i(mask_len_i), .run_q_i(run_q), .run_nxt_i(run_nxt),
    .lock_q(lock_q));

  lkd_out_sel u_sel (
    .lock_q_i(lock_q), .raw_i(raw_lock_i), .stop_i(stop_i),
    .mask_en_i(mask_en_i), .lock_o(lock_o));

  assert_stop_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !lock_q);
endmodule

// File: tb/sim_phase_lock_debounce.sv
module sim_phase_lock_debounce;
  localparam int W = 4;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop = 1'b0;
  logic raw = 1'b0;
  logic [W-1:0] len = '0;
  logic men = 1'b1;
  logic lock;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int m_run = 0;
  bit m_lock = 1'b0;
  string req = "R1";

  always #10 clk = ~clk;

  phase_lock_debounce #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_i(stop), .raw_lock_i(raw),
    .mask_len_i(len), .mask_en_i(men), .lock_o(lock));

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || stop) begin
      m_run = 0; m_lock = 1'b0;
    end else if (raw) begin
      if (m_run < TOP) m_run = m_run + 1;
      m_lock = (m_run >= ((int'(len) == 0) ? 1 : int'(len)));
    end else begin
      m_run = 0; m_lock = 1'b0;
    end
  end

  function automatic bit expect_out();
    if (stop) return 1'b0;
    if (!men) return raw;
    return m_lock;
  endfunction

  task automatic check(input string tag);
    bit e;
    e = expect_out();
    checks++;
    if (lock !== e) begin
      errors++;
      $display("FAIL %s: lock_o=%b expected %b at cycle %0d", tag, lock, e, cycles);
    end
  endtask

  // drive inputs after a falling edge, then compare
  task automatic step(input bit r, input bit s = 1'b0);
    @(negedge clk);
    raw = r; stop = s;
    #2 check(req);
  endtask

  task automatic train(input int hi, input int lo);
    for (int i = 0; i < hi; i++) step(1'b1);
    for (int i = 0; i < lo; i++) step(1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    req = "R1";
    len = 4'd5;
    repeat (3) @(negedge clk);
    #2 check("R1");
    @(negedge clk); rst_n = 1'b1;
    #2 check("R1");
    // R2 exact boundary: L-1 then L
    req = "R2";
    train(4, 1);
    train(5, 1);
    train(8, 2);
    len = 4'd0; train(1, 1);
    len = 4'd1; train(2, 1);
    // R3 chatter
    req = "R3";
    len = 4'd6;
    for (int k = 0; k < 5; k++) train(5, 1);
    train(3, 1); train(1, 1); train(7, 1);
    // R4 unlock right after loss
    req = "R4";
    len = 4'd3;
    train(6, 1); train(4, 3);
    // R5 bypass
    req = "R5";
    men = 1'b0;
    train(1, 1); train(3, 2); step(1'b1, 1'b1); step(1'b1); step(1'b0, 1'b1);
    // R8 run kept during bypass, then enable mask
    req = "R8";
    len = 4'd4;
    train(6, 0);
    @(negedge clk); men = 1'b1; raw = 1'b1; #2 check("R8");
    step(1'b0);
    // R6 stop
    req = "R6";
    train(5, 0);
    step(1'b1, 1'b1); step(1'b1, 1'b1);
    train(3, 0); train(2, 1);
    // R7 saturation at largest mask
    req = "R7";
    len = 4'(TOP);
    train(40, 1);
    train(TOP - 1, 1);
    // R1 reset mid-lock
    req = "R1";
    len = 4'd2;
    train(4, 0);
    @(negedge clk); rst_n = 1'b0; #2 check("R1");
    @(negedge clk); rst_n = 1'b1; raw = 1'b1; #2 check("R1");
    train(3, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule